// File: doc/BRIEF.md
# Receive Frame Unloader and Word Packer

This block empties one received frame out of an Ethernet controller that is reached over a byte-wide I/O port bus. Every 16-bit access is split by an internal sequencer into two byte cycles. A strobe cycle is followed by a capture cycle. The block first fetches the frame's status word and its length word. If the frame is good and the host has a buffer free, it then reads the 14-byte link header as seven 16-bit words. The payload follows: it is packed into big-endian 32-bit words and written to a local buffer memory from word address 0. Bytes beyond the payload end are zeroed.

A frame that is flagged bad, or one that arrives when no buffer is free, is not read any further. The block releases it inside the controller instead. To do this it writes the receive configuration register with the host's configuration value plus the skip bit, using the controller's address-port and data-port pair. Once a frame has been unloaded, the block presents the payload length, the seven header words and a frame-type code. It also keeps running counts of frames, bytes and dropped frames.

A host pulses `start` when the controller reports a received frame. It then waits for either `frame_done` or `frame_skip`.

Top module: `rxf_unloader`

## Requirements
- R1: After reset, `busy`, `bus_rd`, `bus_wr`, `mem_we`, `frame_done` and `frame_skip` are low, and all three counters read zero.
- R2: A frame starts with two 16-bit reads from the frame port, status first and then length. Each read takes port address 1 first and then port address 0. The first byte returned forms the upper byte of the word.
- R3: `payload_len` equals the length word minus 14.
- R4: If bit 8 of the status word is 0 (frame bad), the block makes no further reads. It performs four byte writes, in this order: 0x02 to address 0xA, 0x01 to address 0xB, then the low byte and then the high byte of (`rx_cfg` OR 0x0040) to addresses 0xC and 0xD. After that it pulses `frame_skip`, and the drop counter is unchanged.
- R5: A good frame seen while `buf_free` is low is released with the same four writes as in R4, and `drop_cnt` increases by exactly 1.
- R6: The header is read as seven words, each from address 0 and then address 1. The address-0 byte is the upper byte. Word i appears at `hdr_words[16*i +: 16]`.
- R7: The payload is read as ceil(len/2) words from address 0 and then address 1. Each pair of words is written as one 32-bit word, with the first word in bits 31:16, at buffer addresses 0, 1, 2 and so on. A final unpaired word is written with bits 15:0 zero.
- R8: In the last buffer word, bytes beyond the payload length are zero. When len mod 4 is 1, only bits 31:24 survive. When len mod 4 is 3, bits 7:0 are zero.
- R9: `frame_type` is 1 when header word 6 is 0x0806, 2 when it is 0x0800, and 0 for any other value.
- R10: When a frame has been fully unloaded, `pkt_cnt` increases by 1 and `byte_cnt` increases by len+14. Both new values are visible in the cycle `frame_done` is high.
- R11: `frame_done` and `frame_skip` are single-cycle pulses, never high together, and exactly one of them ends each frame.
- R12: No two consecutive cycles carry a bus strobe (`bus_rd` or `bus_wr`). Every byte cycle is followed by a capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: a received frame is waiting in the controller |
| buf_free | input | 1 | Host has a buffer for the payload; sampled once the length is known |
| rx_cfg | input | 16 | Host's stored receive configuration value |
| busy | output | 1 | A frame is being handled |
| bus_addr | output | 4 | Controller port address of the current byte cycle |
| bus_rd | output | 1 | Byte read strobe |
| bus_wr | output | 1 | Byte write strobe |
| bus_wdata | output | 8 | Byte written during `bus_wr` |
| bus_rdata | input | 8 | Byte returned; must be valid from the strobe cycle through the following capture cycle |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | BUF_AW | Buffer word address |
| mem_wdata | output | 32 | Packed big-endian payload word |
| payload_len | output | 16 | Payload length in bytes (header excluded) |
| hdr_words | output | 16*HDR_WORDS | Link header words, word 0 in the low bits |
| frame_type | output | 2 | 0 other, 1 ARP, 2 IP |
| frame_done | output | 1 | Pulse: frame unloaded |
| frame_skip | output | 1 | Pulse: frame released without unloading |
| pkt_cnt | output | PKT_W | Unloaded-frame count |
| byte_cnt | output | BYTE_W | Unloaded-byte count including headers |
| drop_cnt | output | DROP_W | Frames dropped for lack of a buffer |

## Verification
Every 16-bit access takes five cycles: an idle cycle, then strobe, capture, strobe and capture. The bench therefore checks each byte strobe against the expected transaction in the very cycle it appears, and answers reads in that same strobe cycle. A packed word reaches `mem_we` one cycle after the capture that completes it, and the bench checks it when it appears rather than after a fixed delay. The counters, header words, type and length are checked once `frame_done` or `frame_skip` has been seen, because they are defined to be settled in that cycle. At that point the bench also confirms that no expected strobe or buffer write is still outstanding, so a missing or extra access is reported.

// File: rtl/rxf_pkg.sv
// Package: shared constants and types of the receive frame unloader.
package rxf_pkg;
    localparam logic [3:0]  PORT_FRAME   = 4'h0;   // frame data port pair 0/1
    localparam logic [3:0]  PORT_REGADR  = 4'hA;   // register address port pair
    localparam logic [3:0]  PORT_REGDAT  = 4'hC;   // register data port pair
    localparam logic [15:0] REG_RX_CONF  = 16'h0102;
    localparam logic [15:0] SKIP_FLAG    = 16'h0040;
    localparam int          GOOD_BIT     = 8;
    localparam logic [15:0] LINK_HDR_LEN = 16'd14;
    localparam logic [15:0] ETYPE_ARP    = 16'h0806;
    localparam logic [15:0] ETYPE_IP     = 16'h0800;

    typedef enum logic [1:0] {FT_OTHER = 2'd0, FT_ARP = 2'd1, FT_IP = 2'd2} ftype_e;

    typedef enum logic [3:0] {
        CS_IDLE, CS_STAT, CS_LEN, CS_DEC, CS_HDR, CS_DATA, CS_FIN, CS_SKA, CS_SKD
    } ctl_state_e;
endpackage

// File: rtl/rxf_bus_seq.sv
// Module: rxf_bus_seq
// Splits one 16-bit access into two byte cycles (strobe, capture, strobe,
// capture). Reads put the first byte fetched in the upper half; hi_first
// selects odd-then-even addressing. Writes send the low byte to the even port
// first. Assumes bus_rdata is valid from the strobe cycle until after capture.
module rxf_bus_seq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_wr,
    input  logic        req_hi_first,
    input  logic [3:0]  req_base,
    input  logic [15:0] req_wdata,
    output logic        idle,
    output logic        done,
    output logic [15:0] rdata,
    output logic [3:0]  bus_addr,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata
);
    typedef enum logic [2:0] {SQ_IDLE, SQ_STB0, SQ_CAP0, SQ_STB1, SQ_CAP1} sq_e;

    sq_e         sq;
    logic        op_wr, op_hi;
    logic [3:0]  op_base;
    logic [15:0] op_wdata;
    logic [7:0]  byte0;
    logic        second, strobe;

    // Purpose: step through the four phases of a word access and latch the op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq       <= SQ_IDLE;
            op_wr    <= 1'b0;
            op_hi    <= 1'b0;
            op_base  <= '0;
            op_wdata <= '0;
            byte0    <= '0;
        end else begin
            case (sq)
                SQ_IDLE: if (req) begin
                    op_wr    <= req_wr;
                    op_hi    <= req_hi_first;
                    op_base  <= req_base;
                    op_wdata <= req_wdata;
                    sq       <= SQ_STB0;
                end
                SQ_STB0: sq <= SQ_CAP0;
                SQ_CAP0: begin
                    byte0 <= bus_rdata;
                    sq    <= SQ_STB1;
                end
                SQ_STB1: sq <= SQ_CAP1;
                default: sq <= SQ_IDLE;
            endcase
        end
    end

    // Purpose: drive the byte bus from the current phase and latched op.
    always_comb begin
        second    = (sq == SQ_STB1);
        strobe    = (sq == SQ_STB0) || (sq == SQ_STB1);
        bus_addr  = op_base + {3'b000, second ^ (!op_wr && op_hi)};
        bus_rd    = strobe && !op_wr;
        bus_wr    = strobe && op_wr;
        bus_wdata = second ? op_wdata[15:8] : op_wdata[7:0];
        idle      = (sq == SQ_IDLE);
        done      = (sq == SQ_CAP1);
        rdata     = {byte0, bus_rdata};
    end

    // R12: a strobe is always followed by a capture cycle without strobe
    a_r12_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> !(bus_rd || bus_wr));
    // R12: a completed access was preceded by a strobe cycle
    a_r12_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_rd || bus_wr));
endmodule

// File: rtl/rxf_packer.sv
// Module: rxf_packer
// Packs a stream of 16-bit payload words into big-endian 32-bit buffer words
// at consecutive addresses, masking bytes past the payload end on the last
// word. Assumes clear precedes every frame and len_lo is stable within it.
module rxf_packer #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [15:0]   in_data,
    input  logic [1:0]    len_lo,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata
);
    logic          phase;
    logic [15:0]   hold;
    logic [AW-1:0] waddr;
    logic [31:0]   tail_mask;

    // Purpose: select the byte mask that applies to the final word.
    always_comb begin
        case (len_lo)
            2'd1:    tail_mask = 32'hFF00_0000;
            2'd3:    tail_mask = 32'hFFFF_FF00;
            default: tail_mask = 32'hFFFF_FFFF;
        endcase
    end

    // Purpose: pair words, emit packed writes and advance the buffer address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= 1'b0;
            hold      <= '0;
            waddr     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (clear) begin
                phase <= 1'b0;
                waddr <= '0;
            end else if (in_valid) begin
                if (!phase) begin
                    hold <= in_data;
                    if (in_last) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= waddr;
                        mem_wdata <= {in_data, 16'h0000} & tail_mask;
                    end else begin
                        phase <= 1'b1;
                    end
                end else begin
                    mem_we    <= 1'b1;
                    mem_addr  <= waddr;
                    mem_wdata <= {hold, in_data} & (in_last ? tail_mask : 32'hFFFF_FFFF);
                    waddr     <= waddr + 1'b1;
                    phase     <= 1'b0;
                end
            end
        end
    end

    // R8: with len mod 4 == 1 only the top byte of the last word survives
    a_r8_tail_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(in_valid && in_last) && len_lo == 2'd1) |-> mem_wdata[23:0] == 24'h0);
    // R7: with len mod 4 == 2 the last word has a zero lower half
    a_r7_tail_half: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(in_valid && in_last) && len_lo == 2'd2) |-> mem_wdata[15:0] == 16'h0);
endmodule

// File: rtl/rxf_counters.sv
// Module: rxf_counters
// Frame, byte and drop counters. Assumes each increment input is a
// single-cycle pulse; counters wrap at their width.
module rxf_counters #(
    parameter int PKT_W  = 16,
    parameter int BYTE_W = 32,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_inc,
    input  logic              drop_inc,
    input  logic [15:0]       frame_bytes,
    output logic [PKT_W-1:0]  pkt_cnt,
    output logic [BYTE_W-1:0] byte_cnt,
    output logic [DROP_W-1:0] drop_cnt
);
    // Purpose: accumulate frame, byte and drop totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_cnt  <= '0;
            byte_cnt <= '0;
            drop_cnt <= '0;
        end else begin
            if (pkt_inc) begin
                pkt_cnt  <= pkt_cnt + 1'b1;
                byte_cnt <= byte_cnt + BYTE_W'(frame_bytes);
            end
            if (drop_inc) drop_cnt <= drop_cnt + 1'b1;
        end
    end

    // R5: the drop count only ever moves by one
    a_r5_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1));
    // R10: the frame count only ever moves by one
    a_r10_pkt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt != $past(pkt_cnt)) |-> (pkt_cnt == $past(pkt_cnt) + 1'b1));
endmodule

// File: rtl/rxf_unloader.sv
// Module: rxf_unloader (top)
// Drains one received frame: status and length, then either a skip command or
// the header words and the packed payload. Assumes the length word is at
// least 14 and the payload fits in 2**BUF_AW buffer words.
module rxf_unloader
    import rxf_pkg::*;
#(
    parameter int BUF_AW    = 9,
    parameter int HDR_WORDS = 7,
    parameter int PKT_W     = 16,
    parameter int BYTE_W    = 32,
    parameter int DROP_W    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   buf_free,
    input  logic [15:0]            rx_cfg,
    output logic                   busy,
    output logic [3:0]             bus_addr,
    output logic                   bus_rd,
    output logic                   bus_wr,
    output logic [7:0]             bus_wdata,
    input  logic [7:0]             bus_rdata,
    output logic                   mem_we,
    output logic [BUF_AW-1:0]      mem_addr,
    output logic [31:0]            mem_wdata,
    output logic [15:0]            payload_len,
    output logic [16*HDR_WORDS-1:0] hdr_words,
    output logic [1:0]             frame_type,
    output logic                   frame_done,
    output logic                   frame_skip,
    output logic [PKT_W-1:0]       pkt_cnt,
    output logic [BYTE_W-1:0]      byte_cnt,
    output logic [DROP_W-1:0]      drop_cnt
);
    localparam int HCW      = $clog2(HDR_WORDS);
    localparam int TYPE_IDX = HDR_WORDS - 1;

    ctl_state_e  state;
    logic        good_q;
    logic [15:0] rep_q;
    logic [15:0] nwords;
    logic [15:0] dcnt;
    logic [HCW-1:0] hcnt;
    logic [15:0] hdr_q [HDR_WORDS];

    logic        seq_req, seq_wr, seq_hi, seq_idle, seq_done;
    logic [3:0]  seq_base;
    logic [15:0] seq_wdata, seq_rdata;
    logic        pk_clear, pk_valid, pk_last, drop_inc;
    logic [16:0] nw_wide;

    // Purpose: derive payload length and the number of 16-bit payload reads.
    always_comb begin
        payload_len = rep_q - LINK_HDR_LEN;
        nw_wide     = ({1'b0, payload_len} + 17'd1) >> 1;
        nwords      = nw_wide[15:0];
    end

    // Purpose: choose the word access that the current state needs.
    always_comb begin
        seq_req   = seq_idle && (state inside {CS_STAT, CS_LEN, CS_HDR, CS_DATA, CS_SKA, CS_SKD});
        seq_wr    = (state == CS_SKA) || (state == CS_SKD);
        seq_hi    = (state == CS_STAT) || (state == CS_LEN);
        seq_base  = (state == CS_SKA) ? PORT_REGADR :
                    (state == CS_SKD) ? PORT_REGDAT : PORT_FRAME;
        seq_wdata = (state == CS_SKA) ? REG_RX_CONF : (rx_cfg | SKIP_FLAG);
        pk_clear  = (state == CS_IDLE) && start;
        pk_valid  = (state == CS_DATA) && seq_done;
        pk_last   = (dcnt == nwords - 16'd1);
        drop_inc  = (state == CS_DEC) && good_q && !buf_free;
        busy      = (state != CS_IDLE);
    end

    // Purpose: frame-level sequencing from status fetch to done or skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= CS_IDLE;
            good_q     <= 1'b0;
            rep_q      <= LINK_HDR_LEN;
            dcnt       <= '0;
            hcnt       <= '0;
            frame_done <= 1'b0;
            frame_skip <= 1'b0;
            for (int i = 0; i < HDR_WORDS; i++) hdr_q[i] <= '0;
        end else begin
            frame_done <= (state == CS_FIN);
            frame_skip <= (state == CS_SKD) && seq_done;
            case (state)
                CS_IDLE: if (start) state <= CS_STAT;
                CS_STAT: if (seq_done) begin
                    good_q <= seq_rdata[GOOD_BIT];
                    state  <= CS_LEN;
                end
                CS_LEN: if (seq_done) begin
                    rep_q <= seq_rdata;
                    state <= CS_DEC;
                end
                CS_DEC: begin
                    hcnt  <= '0;
                    state <= (good_q && buf_free) ? CS_HDR : CS_SKA;
                end
                CS_HDR: if (seq_done) begin
                    hdr_q[hcnt] <= seq_rdata;
                    if (hcnt == HCW'(TYPE_IDX)) begin
                        dcnt  <= '0;
                        state <= (nwords == 16'd0) ? CS_FIN : CS_DATA;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                CS_DATA: if (seq_done) begin
                    if (pk_last) state <= CS_FIN;
                    else         dcnt  <= dcnt + 16'd1;
                end
                CS_SKA: if (seq_done) state <= CS_SKD;
                CS_SKD: if (seq_done) state <= CS_IDLE;
                default: state <= CS_IDLE;
            endcase
        end
    end

    // Purpose: flatten header words and classify the frame type.
    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_hdr
        assign hdr_words[16*g +: 16] = hdr_q[g];
    end
    assign frame_type = (hdr_q[TYPE_IDX] == ETYPE_ARP) ? FT_ARP :
                        (hdr_q[TYPE_IDX] == ETYPE_IP)  ? FT_IP  : FT_OTHER;

    rxf_bus_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req(seq_req), .req_wr(seq_wr),
        .req_hi_first(seq_hi), .req_base(seq_base), .req_wdata(seq_wdata),
        .idle(seq_idle), .done(seq_done), .rdata(seq_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    rxf_packer #(.AW(BUF_AW)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(pk_clear), .in_valid(pk_valid),
        .in_last(pk_last), .in_data(seq_rdata), .len_lo(payload_len[1:0]),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    rxf_counters #(.PKT_W(PKT_W), .BYTE_W(BYTE_W), .DROP_W(DROP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .pkt_inc(state == CS_FIN), .drop_inc(drop_inc),
        .frame_bytes(rep_q), .pkt_cnt(pkt_cnt), .byte_cnt(byte_cnt), .drop_cnt(drop_cnt)
    );

    // R4: byte writes happen only while releasing a frame
    a_r4_write_only_skip: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (state == CS_SKA || state == CS_SKD));
    // R11: completion pulses last one cycle and never coincide
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && frame_skip));
    // R7: buffer writes occur only while unloading the payload
    a_r7_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == CS_DATA || state == CS_FIN));
endmodule

// File: tb/tb_rxf_unloader.sv
module tb_rxf_unloader;
    localparam int BUF_AW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, buf_free = 1'b1;
    logic [15:0] rx_cfg = 16'h1100;
    logic busy, bus_rd, bus_wr, mem_we, frame_done, frame_skip;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata = 8'h00;
    logic [BUF_AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [15:0] payload_len;
    logic [111:0] hdr_words;
    logic [1:0] frame_type;
    logic [15:0] pkt_cnt, drop_cnt;
    logic [31:0] byte_cnt;

    always #4 clk = ~clk;   // 125 MHz

    rxf_unloader dut (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_free(buf_free), .rx_cfg(rx_cfg),
        .busy(busy), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .payload_len(payload_len),
        .hdr_words(hdr_words), .frame_type(frame_type), .frame_done(frame_done),
        .frame_skip(frame_skip), .pkt_cnt(pkt_cnt), .byte_cnt(byte_cnt), .drop_cnt(drop_cnt)
    );

    int vectors = 0, errors = 0;
    logic [7:0]  stream [$];          // bytes the controller returns, in order
    logic [12:0] exp_ops [$];         // {wr, addr, data} per byte strobe
    logic [BUF_AW+31:0] exp_mem [$];  // {addr, word}
    bit saw_done = 0, saw_skip = 0;
    int exp_pkt = 0, exp_drop = 0;
    longint exp_bytes = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Controller and buffer model: compares every strobe and write each clock.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (bus_rd || bus_wr) begin
                    logic [12:0] got;
                    got = {bus_wr, bus_addr, bus_wr ? bus_wdata : 8'h00};
                    if (exp_ops.size() == 0) chk("R2/R4 unexpected strobe", 64'(got), 64'h1FFF);
                    else chk("R2/R4/R6/R7 byte cycle", 64'(got), 64'(exp_ops.pop_front()));
                    chk("R12 single strobe kind", 64'(bus_rd & bus_wr), 64'h0);
                    if (bus_rd) bus_rdata = (stream.size() != 0) ? stream.pop_front() : 8'h00;
                end
                if (mem_we) begin
                    if (exp_mem.size() == 0) chk("R7 unexpected buffer write", {mem_addr, mem_wdata}, 64'hFFFF);
                    else chk("R7/R8 buffer write", 64'({mem_addr, mem_wdata}), 64'(exp_mem.pop_front()));
                end
                if (frame_done) saw_done = 1;
                if (frame_skip) saw_skip = 1;
            end
        end
    end

    task automatic push_rd(input logic [3:0] a);
        exp_ops.push_back({1'b0, a, 8'h00});
    endtask

    task automatic run_frame(input logic [15:0] st, input int plen, input logic [15:0] etype,
                             input bit bf, input logic [15:0] cfg, input logic [7:0] seed);
        logic [15:0] rep, skv;
        logic [15:0] hdr [7];
        logic [7:0]  pl [$];
        bit skip;
        int n16;
        logic [1:0] exp_t;
        rep = 16'(plen + 14);
        skip = !st[8] || !bf;
        stream.push_back(st[15:8]);  stream.push_back(st[7:0]);
        stream.push_back(rep[15:8]); stream.push_back(rep[7:0]);
        push_rd(4'h1); push_rd(4'h0); push_rd(4'h1); push_rd(4'h0);   // R2
        for (int i = 0; i < 6; i++) hdr[i] = {seed + 8'(2*i), seed + 8'(2*i+1)};
        hdr[6] = etype;
        if (skip) begin
            skv = cfg | 16'h0040;
            exp_ops.push_back({1'b1, 4'hA, 8'h02});
            exp_ops.push_back({1'b1, 4'hB, 8'h01});
            exp_ops.push_back({1'b1, 4'hC, skv[7:0]});
            exp_ops.push_back({1'b1, 4'hD, skv[15:8]});
            if (st[8]) exp_drop++;
        end else begin
            for (int i = 0; i < 7; i++) begin
                stream.push_back(hdr[i][15:8]); stream.push_back(hdr[i][7:0]);
                push_rd(4'h0); push_rd(4'h1);
            end
            for (int j = 0; j < plen; j++) pl.push_back(8'((seed ^ 8'h5A) + 8'(j*7)));
            n16 = (plen + 1) / 2;
            for (int j = 0; j < 2*n16; j++) begin
                stream.push_back(j < plen ? pl[j] : 8'hEE);   // pad byte must be dropped
                push_rd(j[0] ? 4'h1 : 4'h0);
            end
            for (int w = 0; w < (plen + 3) / 4; w++) begin
                logic [31:0] v;
                v = '0;
                for (int b = 0; b < 4; b++)
                    if (4*w + b < plen) v[31-8*b -: 8] = pl[4*w + b];
                exp_mem.push_back({BUF_AW'(w), v});
            end
            exp_pkt++;
            exp_bytes += plen + 14;
        end
        rx_cfg = cfg; buf_free = bf;
        saw_done = 0; saw_skip = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 3000 && !(saw_done || saw_skip); c++) @(negedge clk);
        chk("R11 frame completed", 64'({saw_done, saw_skip}), skip ? 64'h1 : 64'h2);
        chk("R2/R4/R6/R7 all strobes seen", 64'(exp_ops.size()), 64'h0);
        chk("R7 all buffer words seen", 64'(exp_mem.size()), 64'h0);
        chk("R5 drop count", 64'(drop_cnt), 64'(exp_drop));
        chk("R10 frame count", 64'(pkt_cnt), 64'(exp_pkt));
        chk("R10 byte count", 64'(byte_cnt), 64'(exp_bytes));
        if (!skip) begin
            chk("R3 payload length", 64'(payload_len), 64'(plen));
            for (int i = 0; i < 7; i++) chk("R6 header word", 64'(hdr_words[16*i +: 16]), 64'(hdr[i]));
            exp_t = (etype == 16'h0806) ? 2'd1 : (etype == 16'h0800) ? 2'd2 : 2'd0;
            chk("R9 frame type", 64'(frame_type), 64'(exp_t));
        end
        stream.delete();
        repeat (2) @(negedge clk);
        chk("R11 pulses cleared", 64'({frame_done, frame_skip, busy}), 64'h0);
    endtask

    bit finished = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 idle outputs", 64'({busy, bus_rd, bus_wr, mem_we, frame_done, frame_skip}), 64'h0);
        chk("R1 counters zero", 64'({pkt_cnt, drop_cnt, byte_cnt}), 64'h0);
        // Good frames across all length residues and types (R3 R6 R7 R8 R9 R10)
        run_frame(16'h0104, 0,  16'h0800, 1, 16'h1100, 8'h10);
        run_frame(16'h0104, 1,  16'h0806, 1, 16'h1100, 8'h20);
        run_frame(16'h0104, 2,  16'h0800, 1, 16'h1100, 8'h30);
        run_frame(16'h0104, 3,  16'h86DD, 1, 16'h1100, 8'h40);
        run_frame(16'h0104, 4,  16'h0806, 1, 16'h1100, 8'h50);
        run_frame(16'h0104, 5,  16'h0800, 1, 16'h1100, 8'h60);
        run_frame(16'h0104, 7,  16'h0801, 1, 16'h1100, 8'h70);
        run_frame(16'h0104, 46, 16'h0800, 1, 16'h1100, 8'h80);
        // R4 bad frame: release without reads, drop count unchanged
        run_frame(16'h1004, 20, 16'h0800, 1, 16'h1100, 8'h90);
        run_frame(16'h0004, 3,  16'h0800, 1, 16'hF0BF, 8'h91);
        // R5 no buffer free: release and count the drop
        run_frame(16'h0104, 30, 16'h0800, 0, 16'h1234, 8'hA0);
        run_frame(16'h0104, 9,  16'h0806, 0, 16'h0000, 8'hB0);
        // Recovery after skips
        run_frame(16'h0104, 61, 16'h0806, 1, 16'h1100, 8'hC0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule